// File: doc/BRIEF.md
# Three-Turn Bunch-by-Bunch Damper Filter

This block computes a transverse correction kick for every bunch in a ring running at a fixed revolution frequency. Each cycle that carries a measurement brings a signed position sample and the index of the bunch slot it belongs to. The block first applies a gain-balance factor to the sample. It then forms a weighted sum of that bunch's scaled positions on the current turn and on the two turns before. The result is saturated to the DAC width and handed on, one kick word per bunch, toward the kicker amplifier.

The turn history lives in two chained one-revolution delay lines. Each line is a circular store addressed by bunch slot, so a bunch only ever meets its own earlier measurements. Software picks the three coefficients from the loop gain and the betatron phase wanted at the kicker. For a closed-orbit offset to produce no kick, the coefficients must add up to zero, and the block raises a flag when they do not. After the output is enabled, each bunch yields zero kick until it has three measurements in hand. Disabling the output forces zero kick and restarts that fill-up.

Top module: `turn_damper_filter`

## Requirements
- R1: A kick word appears exactly two clock cycles after its measurement: `kick_valid` equals `in_valid` delayed by two cycles, `kick_slot` equals the delayed `in_slot`, and `kick` is 0 whenever `kick_valid` is low.
- R2: The gain stage yields s = floor(in_pos * gain / 2^GAIN_FRAC). Both operands are signed two's complement, and s is saturated to the signed POS_W range. With defaults, gain 16384 is unity.
- R3: For a slot that has filled, kick = floor((coef0*s[n] + coef1*s[n-1] + coef2*s[n-2]) / 2^COEF_FRAC). Here s[n] is the scaled sample of this slot on the current turn, and s[n-1] and s[n-2] are the scaled samples of the same slot on its two previous visits. With defaults, coefficient 16384 is 1.0.
- R4: History is kept per slot, and slots may arrive in any interleaving. A slot's kick depends only on samples that carried the same `in_slot` value.
- R5: Once `enable` is high, a slot's first two measurements give kick 0. From its third measurement onward, the slot follows R3.
- R6: While `enable` is low, every kick is 0. Every slot's fill-up count is cleared, so after re-enabling, R5 applies again.
- R7: The filter sum is saturated to the signed DAC_W range (-8192..8191 with defaults) and never wraps.
- R8: `coef_err` is registered. One cycle after the coefficients are applied, it is high exactly when coef0+coef1+coef2 is not 0.
- R9: When the coefficients sum to zero, a slot whose position stays constant gets kick 0 once it has filled.
- R10: During and right after reset, `kick_valid`, `kick` and `coef_err` are 0, and all history reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A position measurement is present this cycle |
| in_slot | input | SLOT_W | Bunch slot index of the measurement |
| in_pos | input | POS_W | Signed bunch position |
| gain | input | GAIN_W | Signed gain-balance factor, GAIN_FRAC fraction bits |
| coef0 | input | COEF_W | Signed weight for the current turn |
| coef1 | input | COEF_W | Signed weight for one turn earlier |
| coef2 | input | COEF_W | Signed weight for two turns earlier |
| enable | input | 1 | Output enable; low forces zero kick and restarts fill-up |
| kick_valid | output | 1 | A kick word is present |
| kick_slot | output | SLOT_W | Slot the kick belongs to |
| kick | output | DAC_W | Signed saturated kick word |
| coef_err | output | 1 | Coefficients do not sum to zero |

## Verification
Some properties are checked on every cycle: the fixed two-cycle alignment of valid and slot, the zero kick on empty cycles and while disabled, and the registered coefficient-sum flag. Other behaviour can only be shown by the bench's scenarios, which compare every output against an arithmetic model. That covers the value of the three-turn sum, the floor rounding, saturation at both gain and output, per-slot isolation under permuted slot orders, the two-measurement fill-up after each enable, and the zero response to a constant orbit.

// File: rtl/damper_pkg.sv
package damper_pkg;
    // per-slot fill-up state of the turn history
    typedef enum logic [1:0] {
        FILL_EMPTY  = 2'd0,
        FILL_ONE    = 2'd1,
        FILL_PRIMED = 2'd2
    } fill_e;
endpackage

// File: rtl/dmp_gain_stage.sv
module dmp_gain_stage #(
    parameter int POS_W     = 14,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int SLOT_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [SLOT_W-1:0]        in_slot,
    input  logic signed [POS_W-1:0]  in_pos,
    input  logic signed [GAIN_W-1:0] gain,
    output logic                     out_valid,
    output logic [SLOT_W-1:0]        out_slot,
    output logic signed [POS_W-1:0]  out_pos
);
    localparam int PROD_W = POS_W + GAIN_W;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((2 ** (POS_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

    typedef struct packed {
        logic                    valid;
        logic [SLOT_W-1:0]       slot;
        logic signed [POS_W-1:0] pos;
    } gain_st_t;

    gain_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        st_d       = st_q;
        prod       = PROD_W'(in_pos) * PROD_W'(gain);
        shifted    = prod >>> GAIN_FRAC;
        st_d.valid = in_valid;
        st_d.slot  = in_slot;
        if (shifted > SAT_HI) begin
            st_d.pos = SAT_HI[POS_W-1:0];
        end else if (shifted < SAT_LO) begin
            st_d.pos = SAT_LO[POS_W-1:0];
        end else begin
            st_d.pos = shifted[POS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_slot  = st_q.slot;
    assign out_pos   = st_q.pos;
endmodule

// File: rtl/dmp_turn_history.sv
module dmp_turn_history
    import damper_pkg::*;
#(
    parameter int POS_W  = 14,
    parameter int SLOTS  = 64,
    parameter int SLOT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic signed [POS_W-1:0] wr_sample,
    input  logic                    enable,
    output logic signed [POS_W-1:0] hist1,
    output logic signed [POS_W-1:0] hist2,
    output logic                    primed
);
    typedef struct packed {
        logic [SLOTS-1:0][POS_W-1:0] line1;
        logic [SLOTS-1:0][POS_W-1:0] line2;
        logic [SLOTS-1:0][1:0]       fill;
    } hist_st_t;

    hist_st_t st_d, st_q;

    // reads come from the registered state: the values of earlier turns
    assign hist1  = st_q.line1[wr_slot];
    assign hist2  = st_q.line2[wr_slot];
    assign primed = (st_q.fill[wr_slot] == FILL_PRIMED);

    always_comb begin
        st_d = st_q;
        if (wr_valid) begin
            st_d.line2[wr_slot] = st_q.line1[wr_slot];
            st_d.line1[wr_slot] = wr_sample;
            if (enable && (st_q.fill[wr_slot] != FILL_PRIMED)) begin
                st_d.fill[wr_slot] = st_q.fill[wr_slot] + 2'd1;
            end
        end
        if (!enable) begin
            st_d.fill = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dmp_kick_combine.sv
module dmp_kick_combine #(
    parameter int POS_W     = 14,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 14,
    parameter int DAC_W     = 14,
    parameter int SLOT_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic [SLOT_W-1:0]        slot,
    input  logic signed [POS_W-1:0]  x0,
    input  logic signed [POS_W-1:0]  x1,
    input  logic signed [POS_W-1:0]  x2,
    input  logic signed [COEF_W-1:0] c0,
    input  logic signed [COEF_W-1:0] c1,
    input  logic signed [COEF_W-1:0] c2,
    input  logic                     primed,
    input  logic                     enable,
    output logic                     kick_valid,
    output logic [SLOT_W-1:0]        kick_slot,
    output logic signed [DAC_W-1:0]  kick
);
    localparam int PROD_W = POS_W + COEF_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (DAC_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    typedef struct packed {
        logic                    valid;
        logic [SLOT_W-1:0]       slot;
        logic signed [DAC_W-1:0] kick;
    } comb_st_t;

    comb_st_t st_d, st_q;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] shifted;
    logic signed [DAC_W-1:0] clipped;

    function automatic logic signed [ACC_W-1:0] weigh(
        input logic signed [POS_W-1:0]  a,
        input logic signed [COEF_W-1:0] b
    );
        weigh = ACC_W'(a) * ACC_W'(b);
    endfunction

    always_comb begin
        st_d    = st_q;
        acc     = weigh(x0, c0) + weigh(x1, c1) + weigh(x2, c2);
        shifted = acc >>> COEF_FRAC;
        if (shifted > SAT_HI) begin
            clipped = SAT_HI[DAC_W-1:0];
        end else if (shifted < SAT_LO) begin
            clipped = SAT_LO[DAC_W-1:0];
        end else begin
            clipped = shifted[DAC_W-1:0];
        end
        st_d.valid = valid;
        st_d.slot  = valid ? slot : '0;
        st_d.kick  = (valid && enable && primed) ? clipped : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kick_valid = st_q.valid;
    assign kick_slot  = st_q.slot;
    assign kick       = st_q.kick;
endmodule

// File: rtl/turn_damper_filter.sv
module turn_damper_filter #(
    parameter int POS_W     = 14,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 14,
    parameter int DAC_W     = 14,
    parameter int SLOTS     = 64,
    parameter int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [SLOT_W-1:0]        in_slot,
    input  logic signed [POS_W-1:0]  in_pos,
    input  logic signed [GAIN_W-1:0] gain,
    input  logic signed [COEF_W-1:0] coef0,
    input  logic signed [COEF_W-1:0] coef1,
    input  logic signed [COEF_W-1:0] coef2,
    input  logic                     enable,
    output logic                     kick_valid,
    output logic [SLOT_W-1:0]        kick_slot,
    output logic signed [DAC_W-1:0]  kick,
    output logic                     coef_err
);
    localparam int SUM_W = COEF_W + 2;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;
    logic signed [SUM_W-1:0] coef_sum;

    logic                    g_valid;
    logic [SLOT_W-1:0]       g_slot;
    logic signed [POS_W-1:0] g_pos;
    logic signed [POS_W-1:0] h1;
    logic signed [POS_W-1:0] h2;
    logic                    h_primed;

    always_comb begin
        st_d     = st_q;
        coef_sum = SUM_W'(coef0) + SUM_W'(coef1) + SUM_W'(coef2);
        st_d.err = (coef_sum != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef_err = st_q.err;

    dmp_gain_stage #(
        .POS_W(POS_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .SLOT_W(SLOT_W)
    ) i_gain (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_slot(in_slot), .in_pos(in_pos), .gain(gain),
        .out_valid(g_valid), .out_slot(g_slot), .out_pos(g_pos)
    );

    dmp_turn_history #(
        .POS_W(POS_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
    ) i_hist (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(g_valid), .wr_slot(g_slot), .wr_sample(g_pos), .enable(enable),
        .hist1(h1), .hist2(h2), .primed(h_primed)
    );

    dmp_kick_combine #(
        .POS_W(POS_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
        .DAC_W(DAC_W), .SLOT_W(SLOT_W)
    ) i_comb (
        .clk(clk), .rst_n(rst_n),
        .valid(g_valid), .slot(g_slot), .x0(g_pos), .x1(h1), .x2(h2),
        .c0(coef0), .c1(coef1), .c2(coef2), .primed(h_primed), .enable(enable),
        .kick_valid(kick_valid), .kick_slot(kick_slot), .kick(kick)
    );
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
    parameter int SLOT_W = 6,
    parameter int COEF_W = 16,
    parameter int DAC_W  = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [SLOT_W-1:0]        in_slot,
    input logic                     enable,
    input logic signed [COEF_W-1:0] coef0,
    input logic signed [COEF_W-1:0] coef1,
    input logic signed [COEF_W-1:0] coef2,
    input logic                     kick_valid,
    input logic [SLOT_W-1:0]        kick_slot,
    input logic signed [DAC_W-1:0]  kick,
    input logic                     coef_err
);
    localparam int SUM_W = COEF_W + 2;

    logic [1:0] age;
    logic signed [SUM_W-1:0] sum_now;

    assign sum_now = SUM_W'(coef0) + SUM_W'(coef1) + SUM_W'(coef2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R1
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (kick_valid == $past(in_valid, 2)));

    // R1
    slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && kick_valid) |-> (kick_slot == $past(in_slot, 2)));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kick_valid |-> (kick == '0));

    // R6
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !$past(enable)) |-> (kick == '0));

    // R8
    coef_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1) |-> (coef_err == ($past(sum_now) != '0)));
endmodule

bind turn_damper_filter dmp_checker #(
    .SLOT_W(SLOT_W), .COEF_W(COEF_W), .DAC_W(DAC_W)
) i_dmp_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
    .enable(enable), .coef0(coef0), .coef1(coef1), .coef2(coef2),
    .kick_valid(kick_valid), .kick_slot(kick_slot), .kick(kick),
    .coef_err(coef_err)
);

// File: tb/test_turn_damper_filter.sv
module test_turn_damper_filter;
    localparam int NSLOT = 4;
    localparam int SW    = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [SW-1:0]      in_slot = '0;
    logic signed [13:0] in_pos = '0;
    logic signed [15:0] gain = 16'sd16384;
    logic signed [15:0] coef0 = '0;
    logic signed [15:0] coef1 = '0;
    logic signed [15:0] coef2 = '0;
    logic               enable = 1'b0;
    logic               kick_valid;
    logic [SW-1:0]      kick_slot;
    logic signed [13:0] kick;
    logic               coef_err;

    int n_chk = 0;
    int n_bad = 0;

    longint m_h1 [NSLOT];
    longint m_h2 [NSLOT];
    int     m_fill [NSLOT];
    longint g_m = 16384, c0_m = 0, c1_m = 0, c2_m = 0;
    bit     en_m = 0;

    bit     e1_v = 0, e2_v = 0;
    int     e1_s = 0, e2_s = 0;
    longint e1_k = 0, e2_k = 0;
    string  e1_t = "R1", e2_t = "R1";
    string  cur_req = "R1";

    turn_damper_filter #(.SLOTS(NSLOT)) i_turn_damper_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
        .in_pos(in_pos), .gain(gain), .coef0(coef0), .coef1(coef1),
        .coef2(coef2), .enable(enable), .kick_valid(kick_valid),
        .kick_slot(kick_slot), .kick(kick), .coef_err(coef_err)
    );

    always #5 clk = ~clk;

    function automatic longint sat(input longint v, input int w);
        longint hi = (64'sd1 <<< (w - 1)) - 1;
        longint lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input int slot, input int pos);
        longint s, acc, k;
        @(negedge clk);
        check(e2_t, kick_valid, e2_v);
        if (e2_v) check(e2_t, kick_slot, e2_s);
        check(e2_t, kick, e2_k);
        e2_v = e1_v; e2_s = e1_s; e2_k = e1_k; e2_t = e1_t;
        k = 0;
        if (v) begin
            s   = sat((longint'(pos) * g_m) >>> 14, 14);
            acc = c0_m * s + c1_m * m_h1[slot] + c2_m * m_h2[slot];
            if (en_m && m_fill[slot] == 2) k = sat(acc >>> 14, 14);
            m_h2[slot] = m_h1[slot];
            m_h1[slot] = s;
            if (en_m && m_fill[slot] < 2) m_fill[slot]++;
        end
        e1_v = v; e1_s = v ? slot : 0; e1_k = k; e1_t = cur_req;
        in_valid = v;
        in_slot  = SW'(slot);
        in_pos   = 14'(pos);
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(0, 0, 0);
    endtask

    task automatic set_en(input bit e);
        flush();
        enable = e;
        en_m   = e;
        if (!e) for (int i = 0; i < NSLOT; i++) m_fill[i] = 0;
    endtask

    task automatic set_coefs(input int a, input int b, input int c);
        flush();
        coef0 = 16'(a); coef1 = 16'(b); coef2 = 16'(c);
        c0_m = a; c1_m = b; c2_m = c;
        @(negedge clk);
        check("R8", coef_err, ((a + b + c) != 0) ? 1 : 0);
    endtask

    initial begin
        for (int i = 0; i < NSLOT; i++) begin
            m_h1[i] = 0; m_h2[i] = 0; m_fill[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", kick_valid, 0);
        check("R10", kick, 0);
        check("R10", coef_err, 0);
        rst_n = 1'b1;

        // R8: flag follows the coefficient sum
        set_coefs(100, 200, 300);
        set_coefs(8192, -16384, 8192);
        set_coefs(-1, 0, 0);

        // R3 R4 R5: permuted slot order, varied data, one-in-two zero-sum weights
        set_coefs(8192, -16384, 8192);
        set_en(1);
        for (int t = 0; t < 8; t++) begin
            for (int j = 0; j < NSLOT; j++) begin
                int sl = (t % 2 == 0) ? j : (NSLOT - 1 - j);
                cur_req = (t < 2) ? "R5" : "R4";
                step(1, sl, ((t * 1237 + sl * 911) % 6000) - 3000);
            end
        end
        // R3: asymmetric weights with idle gaps between samples
        set_coefs(12000, -3000, -9000);
        cur_req = "R3";
        for (int t = 0; t < 6; t++) begin
            for (int sl = 0; sl < NSLOT; sl++) begin
                step(1, sl, ((t * 2711 + sl * 433) % 8000) - 4000);
                step(0, 0, 0);
            end
        end

        // R9: constant orbit gives no kick
        set_coefs(5000, -12000, 7000);
        cur_req = "R9";
        for (int t = 0; t < 5; t++)
            for (int sl = 0; sl < NSLOT; sl++) step(1, sl, 1500 - sl * 1000);

        // R2: gain sweep observed through a unity weight on the current turn
        set_coefs(16384, 0, 0);
        cur_req = "R2";
        foreach (g_list[gi]) begin
            flush();
            gain = 16'(g_list[gi]); g_m = g_list[gi];
            for (int p = -8192; p <= 8191; p += 1365)
                step(1, (p + 8192) % NSLOT, p);
            step(1, 0, 8191);
            step(1, 1, -8192);
        end
        flush();
        gain = 16'sd16384; g_m = 16384;

        // R7: output saturation both ways
        set_coefs(32767, -32768, 0);
        cur_req = "R7";
        for (int t = 0; t < 4; t++)
            for (int sl = 0; sl < NSLOT; sl++)
                step(1, sl, (((t + sl) % 2) == 0) ? 8191 : -8192);

        // R6: disabled output, then fresh fill-up after re-enable
        set_coefs(10000, -4000, -6000);
        set_en(0);
        cur_req = "R6";
        for (int t = 0; t < 3; t++)
            for (int sl = 0; sl < NSLOT; sl++) step(1, sl, t * 700 - sl * 300);
        set_en(1);
        for (int t = 0; t < 4; t++)
            for (int sl = 0; sl < NSLOT; sl++) begin
                cur_req = (t < 2) ? "R6" : "R3";
                step(1, sl, 2000 - t * 900 + sl * 250);
            end
        cur_req = "R1";
        flush();
        flush();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int g_list [5] = '{16384, 8192, 24576, -16384, 32767};

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule